// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block translates virtual addresses to physical addresses through a small fully associative buffer of page translations. A requester presents a virtual address with a valid/ready handshake. The buffer compares the virtual page number against every valid entry at once. On a hit, the response carries the physical address and the cache-behaviour attributes in the following cycle, and no memory access takes place.

On a miss, a built-in walker issues one descriptor read to a memory port. It writes the returned descriptor into a victim entry chosen by a round-robin pointer and then replays the held request against the buffer to finish it. Each entry carries a domain number. A sixteen-domain access register decides whether the entry's own permission bits are checked, ignored, or whether the access aborts.

Software controls the block through three inputs. It can pin entries against replacement, with the last entry always left replaceable. It can clear all unpinned entries in one cycle. It can bypass translation altogether with a global enable.

Top module: `tlb_lockable`

## Requirements
- R1: When `enable` is high and the page of an accepted request is resident, `rspValid` pulses in the cycle after acceptance. The response gives `rspPa` = {stored physical page, page offset of the request}, and the walker issues no memory read.
- R2: When `enable` is high and the page is not resident, `memReqValid` rises in the cycle after acceptance and stays high until the cycle in which `memRspValid` is seen. During that time `memReqAddr` holds the requested virtual page number, and exactly one read is made per miss. `rspValid` pulses two cycles after the edge that accepts the descriptor.
- R3: A descriptor (default widths) carries the physical page in bits [29:10], the attributes in [9:6], the domain number in [5:2] and the permission bits in [1:0]. Bit 0 of the permission bits allows reads and bit 1 allows writes.
- R4: The refill victim is the first unlocked entry found at or after the round-robin pointer, searching upward with wrap-around. After a refill the pointer moves to the entry just above the victim, wrapping to 0.
- R5: A `lockWrEn` pulse sets (`lockVal`=1) or clears (`lockVal`=0) the lock of entry `lockIdx`. A locked entry is never chosen as a victim, and its translation stays resident across any number of refills.
- R6: A lock request addressed to the last entry has no effect. That entry is always replaceable, so every refill finds a victim.
- R7: The access rights of domain d are `domainAccess[2d+1:2d]`. 00 and 10 abort the access, 01 checks the entry's permission bits against `reqWrite`, and 11 allows the access without a check.
- R8: An aborted access still returns one `rspValid` pulse, with `rspAbort`=1, `rspPa`=0 and `rspAttr`=0.
- R9: With `enable` low, the next-cycle response gives `rspPa` equal to the request address, with `rspAbort`=0 and `rspAttr`=0, and no memory read is made.
- R10: `reqReady` is low from the cycle after a missing request is accepted until its response, so only one walk is ever outstanding.
- R11: A one-cycle `invalidateAll` pulse invalidates every unlocked entry. Locked entries keep their translations.
- R12: After reset all entries are invalid and unlocked, the round-robin pointer is 0, `reqReady` is 1 and neither `rspValid` nor `memReqValid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Translation on (1) or bypass (0) |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVa | input | VA_W | Virtual address of the request |
| reqWrite | input | 1 | Request is a write (1) or a read (0) |
| rspValid | output | 1 | One-cycle response strobe |
| rspPa | output | VA_W | Physical address |
| rspAttr | output | ATTR_W | Cache-behaviour attributes |
| rspAbort | output | 1 | Access refused by the domain/permission check |
| memReqValid | output | 1 | Descriptor read request, held until answered |
| memReqAddr | output | VA_W-PAGE_W | Virtual page number to fetch |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | DESC_W | Returned descriptor |
| domainAccess | input | 2*DOM_N | Two access bits per domain |
| lockWrEn | input | 1 | Lock update strobe |
| lockIdx | input | IDX_W | Entry whose lock is updated |
| lockVal | input | 1 | New lock value |
| invalidateAll | input | 1 | Invalidate all unlocked entries |

## Verification
The bench builds the block with ENTRIES=8 and leaves the address and descriptor widths at their defaults. With only eight entries, a pool of twelve pages keeps the buffer churning between hits and misses, and the round-robin pointer wraps many times within a few hundred accesses. Locking every entry but the last also becomes cheap to set up, which forces all refills into that single slot. Domain settings are redrawn at random, so all four access codes meet both permission outcomes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WALK   = 2'd1,
    ST_REPLAY = 2'd2
  } tlbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the incoming request
    logic install;  // write the returned descriptor into the victim
    logic respond;  // register a response this cycle
    logic useHeld;  // look up the held request instead of the port
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       enable,
  input  logic       lookupHit,
  input  logic       memRspValid,
  output logic       reqReady,
  output logic       memReqValid,
  output tlbStrobe_t stb
);

  tlbState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          if (!enable || lookupHit) stb.respond = 1'b1;
          else                      stateNext   = ST_WALK;
        end
      end
      ST_WALK: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          stb.install = 1'b1;
          stateNext   = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        stb.useHeld = 1'b1;
        stb.respond = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ATTR_W  = 4,
  parameter int DOM_N   = 16,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int DOM_W  = $clog2(DOM_N),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int DESC_W = VPN_W + ATTR_W + DOM_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         stb,
  input  logic               enable,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic [DESC_W-1:0]  memRspData,
  input  logic [2*DOM_N-1:0] domainAccess,
  input  logic               lockWrEn,
  input  logic [IDX_W-1:0]   lockIdx,
  input  logic               lockVal,
  input  logic               invalidateAll,
  output logic               lookupHit,
  output logic [VPN_W-1:0]   memReqAddr,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspPa,
  output logic [ATTR_W-1:0]  rspAttr,
  output logic               rspAbort,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] lockVec,
  output logic [IDX_W-1:0]   victimIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0]  vpnMem  [ENTRIES];
  logic [VPN_W-1:0]  ppnMem  [ENTRIES];
  logic [ATTR_W-1:0] attrMem [ENTRIES];
  logic [DOM_W-1:0]  domMem  [ENTRIES];
  logic [1:0]        permMem [ENTRIES];

  logic [VA_W-1:0]    heldVa;
  logic               heldWrite;
  logic [IDX_W-1:0]   rrPtr;
  logic [VA_W-1:0]    lookupVa;
  logic               lookupWrite;
  logic [VPN_W-1:0]   lookupVpn;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hitIdx;

  always_ff @(posedge clk) begin
    if (stb.capture) begin
      heldVa    <= reqVa;
      heldWrite <= reqWrite;
    end
  end

  assign lookupVa    = stb.useHeld ? heldVa : reqVa;
  assign lookupWrite = stb.useHeld ? heldWrite : reqWrite;
  assign lookupVpn   = lookupVa[VA_W-1:PAGE_W];
  assign memReqAddr  = heldVa[VA_W-1:PAGE_W];

  // parallel compare against every entry
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = validVec[i] && (vpnMem[i] == lookupVpn);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hitIdx = IDX_W'(i);
  end
  assign lookupHit = |match;

  // first unlocked entry at or above the pointer, wrapping
  always_comb begin
    logic found;
    found     = 1'b0;
    victimIdx = LAST_IDX;
    for (int k = 0; k < ENTRIES; k++) begin
      int cand;
      cand = (int'(rrPtr) + k) % ENTRIES;
      if (!found && !lockVec[cand]) begin
        found     = 1'b1;
        victimIdx = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      lockVec  <= '0;
      rrPtr    <= '0;
    end else begin
      if (invalidateAll) validVec <= validVec & lockVec;
      if (stb.install) begin
        validVec[victimIdx] <= 1'b1;
        rrPtr <= (victimIdx == LAST_IDX) ? '0 : victimIdx + 1'b1;
      end
      if (lockWrEn && lockIdx != LAST_IDX) lockVec[lockIdx] <= lockVal;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.install) begin
      vpnMem[victimIdx]  <= memReqAddr;
      ppnMem[victimIdx]  <= memRspData[DESC_W-1 -: VPN_W];
      attrMem[victimIdx] <= memRspData[DOM_W+2 +: ATTR_W];
      domMem[victimIdx]  <= memRspData[2 +: DOM_W];
      permMem[victimIdx] <= memRspData[1:0];
    end
  end

  // domain and permission check
  logic [1:0] accBits;
  logic       permOk;
  logic       allow;

  always_comb begin
    accBits = domainAccess[{domMem[hitIdx], 1'b0} +: 2];
    permOk  = lookupWrite ? permMem[hitIdx][1] : permMem[hitIdx][0];
    allow   = (accBits == 2'b11) || (accBits == 2'b01 && permOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPa    <= '0;
      rspAttr  <= '0;
      rspAbort <= 1'b0;
    end else begin
      rspValid <= stb.respond;
      if (stb.respond) begin
        if (!enable) begin
          rspPa    <= lookupVa;
          rspAttr  <= '0;
          rspAbort <= 1'b0;
        end else if (allow) begin
          rspPa    <= {ppnMem[hitIdx], lookupVa[PAGE_W-1:0]};
          rspAttr  <= attrMem[hitIdx];
          rspAbort <= 1'b0;
        end else begin
          rspPa    <= '0;
          rspAttr  <= '0;
          rspAbort <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ATTR_W  = 4,
  parameter int DOM_N   = 16,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int DOM_W  = $clog2(DOM_N),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int DESC_W = VPN_W + ATTR_W + DOM_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspPa,
  output logic [ATTR_W-1:0]  rspAttr,
  output logic               rspAbort,
  output logic               memReqValid,
  output logic [VPN_W-1:0]   memReqAddr,
  input  logic               memRspValid,
  input  logic [DESC_W-1:0]  memRspData,
  input  logic [2*DOM_N-1:0] domainAccess,
  input  logic               lockWrEn,
  input  logic [IDX_W-1:0]   lockIdx,
  input  logic               lockVal,
  input  logic               invalidateAll
);

  tlbStrobe_t         stb;
  logic               lookupHit;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] lockVec;
  logic [IDX_W-1:0]   victimIdx;

  tlb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .enable     (enable),
    .lookupHit  (lookupHit),
    .memRspValid(memRspValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .stb        (stb)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_W(PAGE_W),
    .ATTR_W (ATTR_W),  .DOM_N(DOM_N)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .enable       (enable),
    .reqVa        (reqVa),
    .reqWrite     (reqWrite),
    .memRspData   (memRspData),
    .domainAccess (domainAccess),
    .lockWrEn     (lockWrEn),
    .lockIdx      (lockIdx),
    .lockVal      (lockVal),
    .invalidateAll(invalidateAll),
    .lookupHit    (lookupHit),
    .memReqAddr   (memReqAddr),
    .rspValid     (rspValid),
    .rspPa        (rspPa),
    .rspAttr      (rspAttr),
    .rspAbort     (rspAbort),
    .validVec     (validVec),
    .lockVec      (lockVec),
    .victimIdx    (victimIdx)
  );

endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               reqValid,
  input logic               reqReady,
  input logic [VA_W-1:0]    reqVa,
  input logic               lookupHit,
  input logic               rspValid,
  input logic [VA_W-1:0]    rspPa,
  input logic               rspAbort,
  input logic               memReqValid,
  input logic               memRspValid,
  input logic               installStb,
  input logic               invalidateAll,
  input logic               lockWrEn,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] lockVec,
  input logic [IDX_W-1:0]   victimIdx
);

  // R1: a hit completes next cycle without a walk
  a_r1_hit_no_walk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && enable && lookupHit) |=> (rspValid && !memReqValid));

  // R2: response arrives two cycles after the descriptor is taken
  a_r2_replay_timing: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRspValid) |=> (!rspValid && !memReqValid) ##1 rspValid);

  // R5: a refill never lands on a locked entry
  a_r5_victim_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    installStb |-> !lockVec[victimIdx]);

  // R6: the last entry never carries a lock
  a_r6_last_free: assert property (@(posedge clk) disable iff (!rstN)
    !lockVec[ENTRIES-1]);

  // R9: bypass returns the address untouched
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !enable) |=>
      (rspValid && !rspAbort && rspPa == $past(reqVa) && !memReqValid));

  // R10: no new request is taken while a walk is pending
  a_r10_single_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R11: invalidate leaves only locked entries valid
  a_r11_inval_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    (invalidateAll && !installStb && !lockWrEn) |=> ((validVec & ~lockVec) == '0));

endmodule

bind tlb_lockable tlb_lockable_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqVa        (reqVa),
  .lookupHit    (lookupHit),
  .rspValid     (rspValid),
  .rspPa        (rspPa),
  .rspAbort     (rspAbort),
  .memReqValid  (memReqValid),
  .memRspValid  (memRspValid),
  .installStb   (stb.install),
  .invalidateAll(invalidateAll),
  .lockWrEn     (lockWrEn),
  .validVec     (validVec),
  .lockVec      (lockVec),
  .victimIdx    (victimIdx)
);

// File: tb/tlb_lockable_tb.sv
module tlb_lockable_tb;

  localparam int N      = 8;
  localparam int VA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int IDX_W  = $clog2(N);
  localparam int DESC_W = VPN_W + 4 + 4 + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [VA_W-1:0] reqVa = '0;
  logic reqWrite = 1'b0;
  logic rspValid;
  logic [VA_W-1:0] rspPa;
  logic [3:0] rspAttr;
  logic rspAbort;
  logic memReqValid;
  logic [VPN_W-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [DESC_W-1:0] memRspData = '0;
  logic [31:0] domainAccess = '1;
  logic lockWrEn = 1'b0;
  logic [IDX_W-1:0] lockIdx = '0;
  logic lockVal = 1'b0;
  logic invalidateAll = 1'b0;

  always #5 clk = ~clk;

  tlb_lockable #(.ENTRIES(N)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPa(rspPa), .rspAttr(rspAttr), .rspAbort(rspAbort),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .domainAccess(domainAccess), .lockWrEn(lockWrEn), .lockIdx(lockIdx),
    .lockVal(lockVal), .invalidateAll(invalidateAll)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  bit               mValid [N];
  bit               mLock  [N];
  logic [VPN_W-1:0] mVpn   [N];
  int               mRr;
  logic [VPN_W-1:0] pool   [12];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R3 descriptor: ppn[29:10] attr[9:6] dom[5:2] perm[1:0]
  function automatic logic [DESC_W-1:0] descOf(input logic [VPN_W-1:0] v);
    return {v ^ 20'hA5A5A, v[3:0] ^ 4'h9, v[7:4], v[9:8]};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mLock[i] = 0; end
    mRr = 0;
  endtask

  task automatic setLock(input int idx, input bit val);
    @(negedge clk);
    lockWrEn = 1; lockIdx = IDX_W'(idx); lockVal = val;
    @(negedge clk);
    lockWrEn = 0;
    if (idx != N - 1) mLock[idx] = val;   // R6: last entry ignored
  endtask

  task automatic invalidate();
    @(negedge clk);
    invalidateAll = 1;
    @(negedge clk);
    invalidateAll = 0;
    for (int i = 0; i < N; i++) if (!mLock[i]) mValid[i] = 0;   // R11
  endtask

  task automatic access(input logic [VA_W-1:0] va, input bit wr, input string tag);
    logic [VPN_W-1:0] vpn;
    logic [DESC_W-1:0] d;
    logic [1:0] acc;
    bit expWalk, expAbort, allow, permOk, gotRsp, sawReady;
    logic [VA_W-1:0] expPa;
    logic [3:0] expAttr;
    int walks, wait_n;
    vpn = va[VA_W-1:PAGE_W];
    expWalk = 0; expAbort = 0; expAttr = 0; expPa = va;
    if (enable) begin
      bit hit;
      hit = 0;
      for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == vpn) hit = 1;
      if (!hit) begin
        int v;
        expWalk = 1;
        v = -1;
        for (int k = 0; k < N; k++)
          if (v < 0 && !mLock[(mRr + k) % N]) v = (mRr + k) % N;   // R4
        mVpn[v] = vpn; mValid[v] = 1; mRr = (v + 1) % N;
      end
      d = descOf(vpn);
      acc = domainAccess[2*d[5:2] +: 2];
      permOk = wr ? d[1] : d[0];
      allow = (acc == 2'b11) || (acc == 2'b01 && permOk);   // R7
      expAbort = !allow;
      expPa = allow ? {d[29:10], va[PAGE_W-1:0]} : '0;   // R8
      expAttr = allow ? d[9:6] : 4'h0;
    end
    @(negedge clk);
    reqValid = 1; reqVa = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 0;
    walks = 0; gotRsp = 0; sawReady = 0;
    wait_n = $urandom_range(0, 2);
    for (int c = 0; c < 20 && !gotRsp; c++) begin
      if (rspValid) begin
        gotRsp = 1;
      end else begin
        if (memReqValid && reqReady) sawReady = 1;
        if (memReqValid && !memRspValid) begin
          if (wait_n == 0) begin
            chk(memReqAddr == vpn, {tag, " R2 memReqAddr"}, 64'(memReqAddr), 64'(vpn));
            memRspValid = 1; memRspData = descOf(memReqAddr); walks++;
          end else wait_n--;
        end else memRspValid = 0;
        @(negedge clk);
      end
    end
    memRspValid = 0;
    chk(gotRsp, {tag, " R2 response seen"}, 64'(gotRsp), 64'd1);
    chk(walks == int'(expWalk), {tag, expWalk ? " R2 one read on miss" : " R1/R9 no read"},
        64'(walks), 64'(expWalk));
    chk(!sawReady, {tag, " R10 ready low in walk"}, 64'(sawReady), 64'd0);
    chk(rspPa == expPa && rspAbort == expAbort && rspAttr == expAttr,
        {tag, " R1/R7/R8/R9 result"}, {rspAbort, rspAttr, rspPa}, {expAbort, expAttr, expPa});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 12; i++) pool[i] = VPN_W'($urandom());
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memReqValid, "R12 reset outputs",
        {reqReady, rspValid, memReqValid}, 64'b100);

    // R1/R2 directed: miss then hit, manager domains
    domainAccess = '1;
    access({pool[0], 12'h123}, 0, "miss");
    access({pool[0], 12'hABC}, 1, "hit");

    // R9 bypass
    enable = 0;
    access(32'hDEAD_BEEF, 1, "bypass");
    enable = 1;

    // R7/R8 no-access domains abort
    domainAccess = '0;
    access({pool[0], 12'h010}, 0, "abort00");
    domainAccess = {16{2'b10}};
    access({pool[0], 12'h010}, 0, "abort10");
    domainAccess = {16{2'b01}};
    access({pool[0], 12'h010}, 0, "client read");
    access({pool[0], 12'h010}, 1, "client write");
    domainAccess = '1;

    // R5 lock entry 0 (holds pool[0] after reset refill) and churn
    setLock(0, 1);
    for (int i = 1; i < 12; i++) access({pool[i], 12'h0}, 0, "churn");
    for (int i = 1; i < 12; i++) access({pool[i], 12'h4}, 0, "churn2");
    access({pool[0], 12'h7}, 0, "R5 locked kept");

    // R11 invalidate keeps locked entry only
    invalidate();
    access({pool[0], 12'h8}, 0, "R11 locked survives");
    access({pool[5], 12'h8}, 0, "R11 unlocked gone");

    // R6 lock all but last, including a request on the last
    for (int i = 0; i < N; i++) setLock(i, 1);
    for (int i = 1; i < 6; i++) access({pool[i], 12'h1}, 1, "R6 last only");
    access({pool[2], 12'h1}, 0, "R6 evicted");
    for (int i = 0; i < N; i++) setLock(i, 0);

    // R4/R7 random mix
    for (int t = 0; t < 300; t++) begin
      if ($urandom_range(0, 9) == 0) domainAccess = $urandom();
      enable = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 39) == 0) invalidate();
      if ($urandom_range(0, 19) == 0) setLock($urandom_range(0, N - 1), 1'($urandom_range(0, 1)));
      access({pool[$urandom_range(0, 11)], 12'($urandom())}, 1'($urandom_range(0, 1)), "R4 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule